// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 18-bit words from a producer clock domain to a consumer clock domain through a storage array of 256 words, or 512 words when the depth parameter is set to that. Words are stored on the write clock. They are returned in the same order on the read clock. Two sets of pointers track the array, one per clock. Each pointer is one bit wider than the address. Each is handed to the opposite domain as Gray code through a chain of synchronizer flops.

Four active-low status outputs report the fill level. The empty and almost-empty outputs are registered on the read clock. The full and almost-full outputs are registered on the write clock. The almost-empty and almost-full thresholds are not fixed: they come from two offset inputs, which may be changed at any time. A typical setting is 8 for both. With that setting, almost-empty is low at 8 words or fewer and almost-full is low at depth minus 8 words or more.

A write is ignored while full is asserted. A read is ignored while empty is asserted. Neither ignored request moves a pointer.

Top module: `dcf_fifo`

## Requirements
- R1: While rst_ni is low, and after it returns high with no traffic, empty_n_o and aempty_n_o are 0, full_n_o and afull_n_o are 1, and rd_data_o is 0. A reset in the middle of operation discards every stored word.
- R2: Words leave in the order they were accepted. The word for a read accepted at a rising edge of rclk_i is on rd_data_o right after that edge, and it holds until the next accepted read.
- R3: A write request while full_n_o is 0 stores nothing and does not advance the write pointer.
- R4: A read request while empty_n_o is 0 leaves rd_data_o unchanged and does not advance the read pointer.
- R5: empty_n_o is 0 exactly when the read-domain fill level is 0.
- R6: aempty_n_o is 0 when the read-domain fill level is at most ae_off_i (n), and 1 from n+1 upward. Empty therefore implies almost-empty.
- R7: afull_n_o is 0 when the write-domain fill level is at least DEPTH - af_off_i (DEPTH - m), and 1 at DEPTH - m - 1 or below.
- R8: full_n_o is 0 only when the write-domain fill level equals DEPTH. Full therefore implies almost-full.
- R9: A port's own accepted operation updates that port's flags at the same rising edge. A pointer change from the other domain crosses as Gray code, with at most one bit changing per edge. It is reflected in the observing domain's flags within three edges of that domain's clock, or four edges when the two clock edges nearly coincide.
- R10: A change on ae_off_i or af_off_i takes effect at the next rising edge of the clock that owns the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request, sampled on rising wclk_i |
| wr_data_i | input | 18 | Word to store |
| rd_en_i | input | 1 | Read request, sampled on rising rclk_i |
| rd_data_o | output | 18 | Registered output word |
| ae_off_i | input | 8 | Almost-empty offset n (log2 DEPTH bits) |
| af_off_i | input | 8 | Almost-full offset m (log2 DEPTH bits) |
| empty_n_o | output | 1 | Low when no words are held (rclk_i domain) |
| aempty_n_o | output | 1 | Low at n words or fewer (rclk_i domain) |
| afull_n_o | output | 1 | Low at DEPTH - m words or more (wclk_i domain) |
| full_n_o | output | 1 | Low at DEPTH words (wclk_i domain) |

## Verification
Results from a port's own activity are due at the same rising edge: a read word or a flag change caused by a port's own write or read. The bench samples these on the falling edge that follows, right after the request is dropped. Results that need the other domain's pointer may take up to four edges of the observing clock. The bench lets five falling edges of each clock pass before sampling them, and it has no traffic in flight at that point. Offset changes are checked two falling edges of the owning clock after the new value is driven.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int WORD_W      = 18;
  localparam int SYNC_STAGES = 2;
  localparam int DEF_DEPTH   = 256;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl #(
  parameter  int DEPTH = dcf_pkg::DEF_DEPTH,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_s_i,
  input  logic [AW-1:0] af_off_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_n_o,
  output logic          afull_n_o
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, fill_d, thr;
  logic          full_n_q, afull_n_q;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s_i >> i);
  end

  assign wr_fire_o = wr_en_i & full_n_q;
  assign wbin_d    = wbin_q + PW'(wr_fire_o);
  assign fill_d    = wbin_d - rbin_s;
  assign thr       = PW'(DEPTH) - {1'b0, af_off_i};

  // flags computed from next state so own writes show at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wbin_q    <= wbin_d;
      wgray_q   <= wbin_d ^ (wbin_d >> 1);
      full_n_q  <= (fill_d != PW'(DEPTH));
      afull_n_q <= (fill_d < thr);
    end
  end

  assign waddr_o   = wbin_q[AW-1:0];
  assign wbin_o    = wbin_q;
  assign wgray_o   = wgray_q;
  assign full_n_o  = full_n_q;
  assign afull_n_o = afull_n_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
  parameter  int DEPTH = dcf_pkg::DEF_DEPTH,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_s_i,
  input  logic [AW-1:0] ae_off_i,
  output logic          rd_fire_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_n_o,
  output logic          aempty_n_o
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s, fill_d;
  logic          empty_n_q, aempty_n_q;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s_i >> i);
  end

  assign rd_fire_o = rd_en_i & empty_n_q;
  assign rbin_d    = rbin_q + PW'(rd_fire_o);
  assign fill_d    = wbin_s - rbin_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= rbin_d ^ (rbin_d >> 1);
      empty_n_q  <= (fill_d != '0);
      aempty_n_q <= (fill_d > {1'b0, ae_off_i});
    end
  end

  // address of the word handed out by an accepted read this cycle
  assign raddr_o    = rbin_q[AW-1:0];
  assign rbin_o     = rbin_q;
  assign rgray_o    = rgray_q;
  assign empty_n_o  = empty_n_q;
  assign aempty_n_o = aempty_n_q;
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter  int DEPTH = dcf_pkg::DEF_DEPTH,
  parameter  int W     = dcf_pkg::WORD_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter  int DEPTH = dcf_pkg::DEF_DEPTH,
  parameter  int W     = dcf_pkg::WORD_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  output logic [W-1:0]  rd_data_o,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  output logic          empty_n_o,
  output logic          aempty_n_o,
  output logic          afull_n_o,
  output logic          full_n_o
);
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wbin, rbin, wgray, rgray, wgray_s, rgray_s;

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rgray_s_i (rgray_s),
    .af_off_i  (af_off_i),
    .wr_fire_o (wr_fire),
    .waddr_o   (waddr),
    .wbin_o    (wbin),
    .wgray_o   (wgray),
    .full_n_o  (full_n_o),
    .afull_n_o (afull_n_o)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wgray_s_i  (wgray_s),
    .ae_off_i   (ae_off_i),
    .rd_fire_o  (rd_fire),
    .raddr_o    (raddr),
    .rbin_o     (rbin),
    .rgray_o    (rgray),
    .empty_n_o  (empty_n_o),
    .aempty_n_o (aempty_n_o)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  dcf_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  dcf_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (wr_fire),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .re_i    (rd_fire),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter  int DEPTH = dcf_pkg::DEF_DEPTH,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          empty_n_o,
  input logic          aempty_n_o,
  input logic          afull_n_o,
  input logic          full_n_o,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!full_n_o && wr_en_i) |=> $stable(wbin));

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_n_o && rd_en_i) |=> $stable(rbin));

  p_rd_advance_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_n_o && rd_en_i) |=> (rbin == PW'($past(rbin) + 1'b1)));

  p_full_in_afull_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_n_o |-> !afull_n_o);

  p_empty_in_aempty_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_n_o |-> !aempty_n_o);

  p_wgray_step_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));

  p_rgray_step_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .empty_n_o  (empty_n_o),
  .aempty_n_o (aempty_n_o),
  .afull_n_o  (afull_n_o),
  .full_n_o   (full_n_o),
  .wbin       (wbin),
  .rbin       (rbin),
  .wgray      (wgray),
  .rgray      (rgray)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
  localparam int DEPTH = 256;
  localparam int W     = 18;
  localparam int AW    = 8;

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data_o;
  logic [AW-1:0] ae_off = 8'd8, af_off = 8'd8;
  logic          empty_n_o, aempty_n_o, afull_n_o, full_n_o;

  int n_chk = 0, n_fail = 0, seq = 0;
  bit done = 0;
  logic [W-1:0] q[$];

  always #4 wclk = ~wclk;  // 125 MHz
  always #5 rclk = ~rclk;

  dcf_fifo #(.DEPTH(DEPTH), .W(W)) u_dcf_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data_o),
    .ae_off_i(ae_off), .af_off_i(af_off),
    .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o),
    .afull_n_o(afull_n_o), .full_n_o(full_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word(input int pat, input int s);
    if (pat == 0) return W'(s * 37 + 5);
    return s[0] ? 18'h2AAAA : 18'h15555;
  endfunction

  task automatic wr_words(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = word(pat, seq);
      if (full_n_o) q.push_back(wr_data);
      seq++;
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd_one();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic drain(input string req);
    logic [W-1:0] exp;
    while (q.size() > 0) begin
      rd_one();
      exp = q.pop_front();
      chk(req, rd_data_o, exp);
      if (q.size() == 8) chk("R6 R9 aempty at own read to n", aempty_n_o, 1'b0);
    end
  endtask

  task automatic t_reset();
    #20;
    chk("R1 empty_n in reset", empty_n_o, 1'b0);
    chk("R1 aempty_n in reset", aempty_n_o, 1'b0);
    chk("R1 full_n in reset", full_n_o, 1'b1);
    chk("R1 afull_n in reset", afull_n_o, 1'b1);
    chk("R1 rd_data in reset", rd_data_o, '0);
    @(negedge wclk);
    rst_ni = 1'b1;
    settle();
    chk("R1 empty_n idle", empty_n_o, 1'b0);
    chk("R1 full_n idle", full_n_o, 1'b1);
  endtask

  task automatic t_fill_walk();
    wr_words(8, 0);
    settle();
    chk("R5 empty_n at 8", empty_n_o, 1'b1);
    chk("R6 aempty_n at n=8", aempty_n_o, 1'b0);
    wr_words(1, 0);
    settle();
    chk("R6 aempty_n at n+1", aempty_n_o, 1'b1);
    wr_words(238, 0);
    settle();
    chk("R7 afull_n at D-m-1", afull_n_o, 1'b1);
    wr_words(1, 0);
    chk("R7 R9 afull_n at D-m own edge", afull_n_o, 1'b0);
    chk("R8 full_n at D-8", full_n_o, 1'b1);
    wr_words(7, 0);
    chk("R8 full_n at D-1", full_n_o, 1'b1);
    wr_words(1, 0);
    chk("R8 R9 full_n at D own edge", full_n_o, 1'b0);
    wr_words(3, 1);
    settle();
    chk("R3 full_n after writes while full", full_n_o, 1'b0);
    chk("R3 model holds D words", q.size(), DEPTH);
  endtask

  task automatic t_drain_empty();
    logic [W-1:0] hold;
    drain("R2 R3 order after full");
    chk("R5 R9 empty_n after last own read", empty_n_o, 1'b0);
    hold = rd_data_o;
    rd_one();
    rd_one();
    chk("R4 rd_data held on empty reads", rd_data_o, hold);
    settle();
    chk("R5 empty_n stays low", empty_n_o, 1'b0);
    chk("R8 full_n after drain", full_n_o, 1'b1);
    wr_words(1, 1);
    settle();
    chk("R4 one word visible", empty_n_o, 1'b1);
    drain("R4 pointer not moved by empty reads");
  endtask

  task automatic t_offsets();
    wr_words(20, 1);
    settle();
    ae_off = 8'd20;
    repeat (2) @(negedge rclk);
    chk("R10 R6 aempty_n at n=20", aempty_n_o, 1'b0);
    ae_off = 8'd19;
    repeat (2) @(negedge rclk);
    chk("R10 R6 aempty_n at n=19", aempty_n_o, 1'b1);
    ae_off = 8'd0;
    repeat (2) @(negedge rclk);
    chk("R10 R6 aempty_n at n=0", aempty_n_o, 1'b1);
    af_off = 8'd236;
    repeat (2) @(negedge wclk);
    chk("R10 R7 afull_n at m=236", afull_n_o, 1'b0);
    af_off = 8'd235;
    repeat (2) @(negedge wclk);
    chk("R10 R7 afull_n at m=235", afull_n_o, 1'b1);
    ae_off = 8'd8;
    af_off = 8'd8;
    drain("R2 alternating pattern");
  endtask

  task automatic t_stream();
    fork
      wr_words(150, 0);
      begin
        int issued = 0, got = 0;
        bit fired = 0;
        logic [W-1:0] exp;
        while (got < 150) begin
          @(negedge rclk);
          if (fired) begin
            exp = q.pop_front();
            chk("R2 concurrent stream", rd_data_o, exp);
            got++;
          end
          rd_en = empty_n_o && (issued < 150);
          fired = rd_en;
          if (fired) issued++;
        end
        rd_en = 1'b0;
      end
    join
    settle();
    chk("R5 empty_n after stream", empty_n_o, 1'b0);
  endtask

  task automatic t_mid_reset();
    wr_words(5, 0);
    settle();
    @(negedge wclk);
    rst_ni = 1'b0;
    #1;
    chk("R1 empty_n mid reset", empty_n_o, 1'b0);
    chk("R1 aempty_n mid reset", aempty_n_o, 1'b0);
    chk("R1 afull_n mid reset", afull_n_o, 1'b1);
    q.delete();
    @(negedge wclk);
    rst_ni = 1'b1;
    settle();
    chk("R1 empty_n after mid reset", empty_n_o, 1'b0);
    wr_words(2, 1);
    settle();
    drain("R1 fresh start after reset");
  endtask

  initial begin
    t_reset();
    t_fill_walk();
    t_drain_empty();
    t_offsets();
    t_stream();
    t_mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule